// File: doc/BRIEF.md
# CAN Frame Transmitter

This block turns one message, held in parallel on its inputs, into a serial CAN data or remote frame. Both identifier widths are handled: the 11-bit base format and the 29-bit extended format. A start request arms the block. It then waits until the bus has been idle for long enough and shifts the frame out one bit per bit-time strobe. The strobe comes from an external bit-timing unit, so the bit rate is set outside the block.

While sending, the block inserts stuff bits and accumulates the 15-bit CRC. It then appends the CRC and the fixed trailer fields. Every bit it drives is compared with the bus value sampled on the same strobe. A recessive bit overwritten by a dominant one inside the arbitration field means another node has won. The block releases the bus and flags the loss. Any other mismatch is a bit error. A recessive ACK slot is an acknowledge error. Every outcome flag is sticky until the next accepted start.

Top module: `can_frame_tx`

## Requirements
- R1: After an accepted start, the start-of-frame bit (dominant, 0) is driven only after 11 consecutive strobes that sample the bus recessive (1). A dominant sample restarts that count.
- R2: A base-format frame is sent as: start-of-frame 0, identifier bits 10..0, remote bit, a dominant extension bit, a dominant reserved bit, length code bits 3..0, data, CRC, trailer. Every field is sent MSB first.
- R3: An extended-format frame is sent as: start-of-frame 0, identifier bits 28..18, two recessive bits (substitute-remote and extension), identifier bits 17..0, remote bit, two dominant reserved bits, length code bits 3..0, data, CRC, trailer.
- R4: The data field carries min(length code, 8) bytes taken from payload[63:56] downward, MSB first. A remote frame carries no data. The length code itself is always sent unmodified.
- R5: From start-of-frame through the last CRC bit, each run of five equal transmitted bits (stuff bits included) is followed by one stuff bit of the opposite value. This also applies after the final CRC bit. The trailer is never stuffed.
- R6: The CRC is 15 bits with generator 0x4599 and a zero initial value. It is computed over the unstuffed bits from start-of-frame through the last data bit and sent MSB first.
- R7: The trailer is CRC delimiter 1, ACK slot 1, ACK delimiter 1, then seven end-of-frame bits 1. `done` rises on the strobe that samples the last end-of-frame bit correctly.
- R8: Sending 1 while sampling 0 on a non-stuff bit of the arbitration field sets `arb_lost`. The arbitration field is the identifier plus remote bit, and in extended format also the substitute-remote and extension bits. From that strobe on, the block drives recessive.
- R9: Any other mismatch between the driven and sampled value sets `bit_err` and releases the bus to recessive. This covers a 0 read back as 1 anywhere, and a 1 read back as 0 outside the arbitration field or on a stuff bit. The ACK slot is excepted.
- R10: If the ACK slot is sampled recessive, `ack_err` is set, `done` stays low, and the bus is released.
- R11: After reset, and while no frame is active, `tx_bit` is recessive. `done`, `arb_lost`, `bit_err` and `ack_err` are low after reset, are cleared by an accepted start, and at most one of them is high at a time.
- R12: `tx_bit` changes only in the clock cycle after a cycle with `bit_tick` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send the presented message (taken when no frame is active) |
| ext_fmt | input | 1 | 1 selects the 29-bit identifier format |
| remote | input | 1 | 1 sends a remote frame |
| ident | input | 29 | Identifier; base format uses bits 10..0 |
| dlc | input | 4 | Length code |
| payload | input | 64 | Data bytes, first byte in bits 63:56 |
| bit_tick | input | 1 | One-cycle strobe marking the sample point of each bit time |
| rx_bit | input | 1 | Bus value sampled at the strobe |
| tx_bit | output | 1 | Line to the transceiver, 1 = recessive |
| done | output | 1 | Frame completed and acknowledged |
| arb_lost | output | 1 | Arbitration lost, bus released |
| bit_err | output | 1 | Bit error detected, bus released |
| ack_err | output | 1 | No acknowledge seen |

## Verification
A bad stuff-run count or source-shift state shows up on `tx_bit` within one strobe of the fault. Every later bit of the stream is then displaced, so comparing the whole serial stream bit by bit exposes it immediately. A corrupted CRC register surfaces only once the CRC field begins, up to 64 data bits later. A wrong arbitration window or ACK-slot marker appears on the flags at the very strobe where the bench injects a mismatch. A stuck idle counter changes how many recessive strobes pass before start-of-frame.

// File: rtl/can_frame_tx.sv
module can_frame_tx #(
  parameter int          IDLE_BITS = 11,
  parameter int          STUFF_RUN = 5,
  parameter int          EOF_LEN   = 7,
  parameter logic [14:0] CRC_POLY  = 15'h4599
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ext_fmt,
  input  logic        remote,
  input  logic [28:0] ident,
  input  logic [3:0]  dlc,
  input  logic [63:0] payload,
  input  logic        bit_tick,
  input  logic        rx_bit,
  output logic        tx_bit,
  output logic        done,
  output logic        arb_lost,
  output logic        bit_err,
  output logic        ack_err
);
  localparam int HDR_S    = 19;
  localparam int HDR_E    = 39;
  localparam int SRC_W    = HDR_E + 64 + 1;
  localparam int LW       = $clog2(SRC_W + 1);
  localparam int IW       = $clog2(IDLE_BITS);
  localparam int RW       = $clog2(STUFF_RUN + 1);
  localparam int TAIL_LEN = 3 + EOF_LEN;
  localparam int TW       = $clog2(TAIL_LEN);

  typedef enum logic [1:0] {S_OFF, S_WAIT, S_BODY, S_TAIL} st_t;
  st_t st;

  logic [SRC_W-1:0] sh;
  logic [LW-1:0]    left, pos;
  logic [14:0]      crc;
  logic             in_crc, ext_q, run_val, cur_arb, cur_ack;
  logic [RW-1:0]    run_cnt;
  logic [IW-1:0]    idle_cnt;
  logic [TW-1:0]    tail_cnt;

  wire [3:0]    nbytes  = remote ? 4'd0 : (dlc > 4'd8 ? 4'd8 : dlc);
  wire [HDR_S-1:0] hdr_s = {1'b0, ident[10:0], remote, 2'b00, dlc};
  wire [HDR_E-1:0] hdr_e = {1'b0, ident[28:18], 2'b11, ident[17:0], remote, 2'b00, dlc};
  wire          src_bit  = sh[SRC_W-1];
  wire          crc_fb   = src_bit ^ crc[14];
  wire [14:0]   crc_upd  = {crc[13:0], 1'b0} ^ (crc_fb ? CRC_POLY : 15'd0);
  wire          need_stf = (run_cnt == RW'(STUFF_RUN));
  wire [LW-1:0] arb_hi   = ext_q ? LW'(32) : LW'(12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; sh <= '0; left <= '0; pos <= '0; crc <= '0;
      in_crc <= 1'b0; ext_q <= 1'b0; run_val <= 1'b0; run_cnt <= '0;
      cur_arb <= 1'b0; cur_ack <= 1'b0; idle_cnt <= '0; tail_cnt <= '0;
      tx_bit <= 1'b1; done <= 1'b0; arb_lost <= 1'b0; bit_err <= 1'b0; ack_err <= 1'b0;
    end else begin
      case (st)
        S_OFF: if (start) begin
          sh       <= ext_fmt ? {hdr_e, payload, 1'b0} : {hdr_s, payload, 21'b0};
          left     <= (ext_fmt ? LW'(HDR_E) : LW'(HDR_S)) + LW'({nbytes, 3'b000});
          ext_q    <= ext_fmt;
          crc      <= '0;
          in_crc   <= 1'b0;
          idle_cnt <= '0;
          done <= 1'b0; arb_lost <= 1'b0; bit_err <= 1'b0; ack_err <= 1'b0;
          st       <= S_WAIT;
        end
        S_WAIT: if (bit_tick) begin
          if (!rx_bit) idle_cnt <= '0;
          else if (idle_cnt == IW'(IDLE_BITS - 1)) begin
            tx_bit  <= src_bit;
            sh      <= sh << 1;
            left    <= left - 1'b1;
            crc     <= crc_upd;
            pos     <= LW'(1);
            run_val <= src_bit;
            run_cnt <= RW'(1);
            cur_arb <= 1'b0;
            cur_ack <= 1'b0;
            st      <= S_BODY;
          end else idle_cnt <= idle_cnt + 1'b1;
        end
        default: if (bit_tick) begin
          if (cur_ack && rx_bit) begin
            ack_err <= 1'b1; tx_bit <= 1'b1; cur_ack <= 1'b0; st <= S_OFF;
          end else if (!cur_ack && tx_bit && !rx_bit && cur_arb) begin
            arb_lost <= 1'b1; tx_bit <= 1'b1; st <= S_OFF;
          end else if (!cur_ack && (tx_bit != rx_bit)) begin
            bit_err <= 1'b1; tx_bit <= 1'b1; st <= S_OFF;
          end else if (st == S_TAIL) begin
            cur_ack <= (tail_cnt == '0);
            if (tail_cnt == TW'(TAIL_LEN - 1)) begin
              done <= 1'b1; st <= S_OFF;
            end else tail_cnt <= tail_cnt + 1'b1;
          end else if (need_stf) begin
            tx_bit  <= ~run_val;
            run_val <= ~run_val;
            run_cnt <= RW'(1);
            cur_arb <= 1'b0;
          end else if (left != '0) begin
            tx_bit  <= src_bit;
            sh      <= sh << 1;
            left    <= left - 1'b1;
            run_val <= src_bit;
            run_cnt <= (src_bit == run_val) ? run_cnt + 1'b1 : RW'(1);
            if (!in_crc) begin
              crc     <= crc_upd;
              pos     <= pos + 1'b1;
              cur_arb <= (pos != '0) && (pos <= arb_hi);
              if (left == LW'(1)) begin
                sh[SRC_W-1 -: 15] <= crc_upd;
                left              <= LW'(15);
                in_crc            <= 1'b1;
              end
            end else cur_arb <= 1'b0;
          end else begin
            tx_bit   <= 1'b1;
            tail_cnt <= '0;
            cur_ack  <= 1'b0;
            cur_arb  <= 1'b0;
            st       <= S_TAIL;
          end
        end
      endcase
    end
  end

  a_r12_tx_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_bit));
  a_r11_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF || st == S_WAIT) |-> tx_bit);
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, arb_lost, bit_err, ack_err}) <= 1);
  a_r8_released_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> tx_bit);
  a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RW'(STUFF_RUN));
  a_r1_sof_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BODY && $past(st) == S_WAIT) |-> !tx_bit);
  a_r10_ack_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_err) |-> $past(cur_ack));
endmodule

// File: tb/sim_can_frame_tx.sv
module sim_can_frame_tx;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ext_fmt = 1'b0, remote = 1'b0;
  logic [28:0] ident = '0;
  logic [3:0]  dlc = '0;
  logic [63:0] payload = '0;
  logic bit_tick = 1'b0, rx_bit = 1'b1;
  logic tx_bit, done, arb_lost, bit_err, ack_err;

  can_frame_tx u0 (.clk(clk), .rst_n(rst_n), .start(start), .ext_fmt(ext_fmt),
    .remote(remote), .ident(ident), .dlc(dlc), .payload(payload), .bit_tick(bit_tick),
    .rx_bit(rx_bit), .tx_bit(tx_bit), .done(done), .arb_lost(arb_lost),
    .bit_err(bit_err), .ack_err(ack_err));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  bit ub[0:159];
  int un;
  bit es[0:255];
  bit ea[0:255];
  int elen, ack_idx;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input bit r);
    @(negedge clk); rx_bit = r; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic put(input bit b);
    ub[un] = b; un++;
  endtask

  task automatic build(input bit e, input bit r, input logic [28:0] id,
                       input logic [3:0] d, input logic [63:0] p);
    bit [14:0] c;
    int nby, ahi, run;
    bit last;
    c = '0; un = 0; elen = 0; run = 0; last = 1'b0;
    put(1'b0);
    if (e) begin
      for (int i = 28; i >= 18; i--) put(id[i]);
      put(1'b1); put(1'b1);
      for (int i = 17; i >= 0; i--) put(id[i]);
      put(r); put(1'b0); put(1'b0); ahi = 32;
    end else begin
      for (int i = 10; i >= 0; i--) put(id[i]);
      put(r); put(1'b0); put(1'b0); ahi = 12;
    end
    for (int i = 3; i >= 0; i--) put(d[i]);
    nby = r ? 0 : (d > 4'd8 ? 8 : int'(d));
    for (int i = 0; i < nby * 8; i++) put(p[63 - i]);
    for (int i = 0; i < un; i++) begin
      bit fb;
      fb = ub[i] ^ c[14];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    for (int i = 14; i >= 0; i--) put(c[i]);
    for (int i = 0; i < un; i++) begin
      es[elen] = ub[i]; ea[elen] = (i >= 1 && i <= ahi); elen++;
      if (i == 0 || ub[i] != last) begin last = ub[i]; run = 1; end
      else run++;
      if (run == 5) begin
        es[elen] = !last; ea[elen] = 1'b0; elen++;
        last = !last; run = 1;
      end
    end
    for (int i = 0; i < 10; i++) begin
      if (i == 1) ack_idx = elen;
      es[elen] = 1'b1; ea[elen] = 1'b0; elen++;
    end
  endtask

  // mode: 0 acknowledged, 1 no ack, 2 arbitration loss, 3 recessive read dominant
  // outside arbitration, 4 dominant read recessive in arbitration field
  task automatic run_frame(input bit e, input bit r, input logic [28:0] id,
                           input logic [3:0] d, input logic [63:0] p,
                           input int mode, input bit interrupt, input string tag);
    int inj, n, mism, first_bad;
    bit v;
    logic [3:0] act, exp;
    build(e, r, id, d, p);
    inj = -1; v = 1'b1;
    if (mode == 1) begin inj = ack_idx; v = 1'b1; end
    for (int k = 0; k < elen && inj < 0; k++) begin
      if (mode == 2 && ea[k] && es[k]) begin inj = k; v = 1'b0; end
      if (mode == 3 && !ea[k] && k > 0 && es[k] && k < ack_idx) begin inj = k; v = 1'b0; end
      if (mode == 4 && ea[k] && !es[k]) begin inj = k; v = 1'b1; end
    end
    ext_fmt = e; remote = r; ident = id; dlc = d; payload = p;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk({done, arb_lost, bit_err, ack_err} == 4'b0 && tx_bit, "R11 flags cleared by start",
        {done, arb_lost, bit_err, ack_err}, 0);
    if (interrupt) begin
      repeat (5) tick(1'b1);
      tick(1'b0);
    end
    n = 0;
    while (tx_bit && n < 40) begin tick(1'b1); n++; end
    chk(n == 11, "R1 recessive strobes before start-of-frame", n, 11);
    mism = 0; first_bad = -1;
    for (int k = 0; k < elen; k++) begin
      bit rr;
      if (k == 5 && mode == 0) begin
        repeat (20) @(negedge clk);
        chk(tx_bit === es[5], "R12 line held without strobe", tx_bit, es[5]);
      end
      if (tx_bit !== es[k]) begin mism++; if (first_bad < 0) first_bad = k; end
      if (k == inj) rr = v;
      else if (k == ack_idx) rr = 1'b0;
      else rr = tx_bit;
      tick(rr);
      if (k == inj) break;
    end
    chk(mism == 0, tag, first_bad, -1);
    exp = {mode == 0, mode == 2, mode == 3 || mode == 4, mode == 1};
    act = {done, arb_lost, bit_err, ack_err};
    case (mode)
      0: chk(act == exp, "R7 done after end-of-frame", act, exp);
      1: chk(act == exp, "R10 missing acknowledge", act, exp);
      2: chk(act == exp, "R8 arbitration lost", act, exp);
      default: chk(act == exp, "R9 bit error", act, exp);
    endcase
    if (mode != 0) begin
      n = 0;
      for (int k = 0; k < 4; k++) begin
        if (!tx_bit) n++;
        tick(1'b1);
      end
      chk(n == 0 && tx_bit, "R8 R9 R10 bus released after abort", n, 0);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({tx_bit, done, arb_lost, bit_err, ack_err} == 5'b10000, "R11 reset state",
        {tx_bit, done, arb_lost, bit_err, ack_err}, 5'b10000);
    @(negedge clk); rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(tx_bit === 1'b1, "R11 R12 recessive with no strobe", tx_bit, 1);

    // stuffing-heavy base frames: all zeros, all ones (R2 R5 R6)
    run_frame(1'b0, 1'b0, 29'h0, 4'd8, 64'h0, 0, 1'b0, "R2 R5 R6 stream all-zero base frame");
    run_frame(1'b0, 1'b0, 29'h7FF, 4'd8, {64{1'b1}}, 0, 1'b0, "R2 R5 R6 stream all-one base frame");
    run_frame(1'b1, 1'b0, 29'h1ABCDEF5, 4'd3, 64'hA55A_0F00_0000_0000, 0, 1'b0,
              "R3 R6 R7 stream extended frame");
    run_frame(1'b0, 1'b1, 29'h123, 4'd5, 64'hFFFF_0000_FFFF_0000, 0, 1'b0, "R4 remote frame without data");
    run_frame(1'b1, 1'b0, 29'h00000001, 4'd12, 64'h0123_4567_89AB_CDEF, 0, 1'b0,
              "R4 length code above eight clamps data");
    run_frame(1'b0, 1'b0, 29'h555, 4'd1, 64'h3C00_0000_0000_0000, 0, 1'b1, "R1 R2 stream after idle restart");
    run_frame(1'b0, 1'b0, 29'h0F0, 4'd2, 64'h1234_0000_0000_0000, 2, 1'b0, "R8 stream before loss");
    run_frame(1'b1, 1'b0, 29'h0, 4'd1, 64'h8000_0000_0000_0000, 2, 1'b0, "R8 extended loss on recessive bit");
    run_frame(1'b0, 1'b0, 29'h0AA, 4'd2, 64'hFF00_0000_0000_0000, 3, 1'b0, "R9 stream before outer error");
    run_frame(1'b0, 1'b0, 29'h3C3, 4'd1, 64'h0, 4, 1'b0, "R9 stream before arbitration-field error");
    run_frame(1'b0, 1'b0, 29'h321, 4'd4, 64'hDEAD_BEEF_0000_0000, 1, 1'b0, "R10 stream before ack slot");

    for (int t = 0; t < 16; t++) begin
      logic [63:0] pr;
      pr = {$urandom, $urandom};
      if (t % 4 == 0) pr = 64'h0;
      run_frame(1'($urandom % 2), 1'($urandom % 5 == 0), 29'($urandom), 4'($urandom % 16),
                pr, 0, 1'b0, "R2 R3 R4 R5 R6 R7 random frame stream");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule